// File: doc/BRIEF.md
# Write-Once Security Area and Sector Lock Registers

This block holds the protected storage area of a serial flash device. It keeps a 128-byte security area whose lower half the user may program exactly once and whose upper half carries a fixed serial value supplied as a parameter. Beside it sits a per-sector lock register: once a sector is locked it stays locked, and any program or erase request aimed at one of its pages is flagged for rejection. Both registers are nonvolatile on the real device. Here they are ordinary registers that come out of reset in the unprogrammed state.

An SPI front end decodes opcodes, skips address and dummy bytes, and then drives this block through a small session interface. `sess_start` opens a session with an operation code on `sess_op`. `din_valid`/`din` carry the payload bytes of a program session. `rd_req` asks for the next byte of a read session. `sess_end` closes the session and corresponds to chip select going high. A separate page-check port answers whether a page lies in a locked sector. The front end combines that answer with the other protection state.

Top module: `otp_secure_regs`

## Requirements
- R1: After reset, `rd_valid` and `acc_reject` are 0, `lock_mask` is all zeros, and every user byte of the security area reads FFh.
- R2: In a session opened with `sess_op` = 00b (security read), each `rd_req` cycle returns the next byte on `rd_data`, starting at byte 0, with `rd_valid` high in the following cycle.
- R3: Security bytes 0..63 read back the user area. Byte 64+k reads byte k of `FACTORY_ID` (bits 8k+7..8k), whose default byte k is (29·k mod 256) xor A5h.
- R4: Once byte 127 has been returned, every further read in the same session returns `PAD_BYTE` (default 5Ah).
- R5: In the first session opened with `sess_op` = 01b (security program), the n-th payload byte (n from 0) is written to user byte n for n < 64. User bytes that are not written stay FFh, and payload bytes with n >= 64 change nothing.
- R6: When the first security program session has ended, the user area is sealed, and later program sessions leave all 128 bytes unchanged.
- R7: In a session opened with `sess_op` = 10b (lock read), reads return one byte per sector in ascending sector order. Each byte is FFh for a locked sector and 00h for an unlocked one. After the last sector, reads return `PAD_BYTE`.
- R8: In a session opened with `sess_op` = 11b (lock program), payload byte n targets sector n. Only the value FFh locks the sector. Any other value, and any byte with n >= the number of sectors, is discarded.
- R9: A locked sector never returns to unlocked, and bit s of `lock_mask` is 1 exactly when sector s is locked.
- R10: One cycle after `acc_valid` with page `acc_page`, `acc_reject` is 1 exactly when the sector in the top two page bits (`acc_page[8:7]`) is locked. `acc_reject` is 0 in a cycle that follows no request.
- R11: `rd_req` outside a read session produces no `rd_valid`, and payload bytes outside a program session change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | Opens a session, latches `sess_op` |
| sess_op | input | 2 | 00 security read, 01 security program, 10 lock read, 11 lock program |
| sess_end | input | 1 | Closes the open session |
| din_valid | input | 1 | Payload byte strobe |
| din | input | 8 | Payload byte |
| rd_req | input | 1 | Request the next read byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| rd_data | output | 8 | Read byte |
| acc_valid | input | 1 | Page check request |
| acc_page | input | 9 | Page address to check |
| acc_reject | output | 1 | Requested page lies in a locked sector |
| lock_mask | output | 4 | One bit per locked sector |

## Verification
A wrong seal flag shows up as a user byte that changes after a second program session. It is visible on the very next read pass of the security area. A wrong lock bit appears at once on `lock_mask`, and it flips `acc_reject` one cycle after the next page check into that sector. A read pointer that is off by one shifts every later byte, so the first compared byte of a read session already mismatches. A pointer that fails to stop shows up as non-pad data after byte 127.

// File: rtl/otp_pkg.sv
// Shared types and the default factory serial for the security area block.
package otp_pkg;

    typedef enum logic [1:0] {
        OP_SEC_RD  = 2'b00,
        OP_SEC_WR  = 2'b01,
        OP_LCK_RD  = 2'b10,
        OP_LCK_WR  = 2'b11
    } otp_op_e;

    // Default serial: byte k = (29*k mod 256) xor A5h, for 64 bytes.
    function automatic logic [511:0] make_serial();
        logic [511:0] s;
        s = '0;
        for (int k = 0; k < 64; k++) begin
            s[8*k +: 8] = 8'(k * 29) ^ 8'hA5;
        end
        return s;
    endfunction

endpackage

// File: rtl/otp_user_array.sv
// Write-once user store. Holds the user half of the security area.
// Assumes: writes arrive only while a program session is open; commit
// marks the end of that session and seals the array for good.
module otp_user_array #(
    parameter int N_BYTES = 64,
    parameter int IDX_W   = $clog2(N_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 commit,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte,
    output logic                 sealed,
    output logic [8*N_BYTES-1:0] flat
);

    logic [7:0] mem [N_BYTES];

    // Store bytes until sealed; the first commit seals permanently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) mem[i] <= 8'hFF;
            sealed <= 1'b0;
        end else begin
            if (wr_en && !sealed) mem[wr_idx] <= wr_data;
            if (commit) sealed <= 1'b1;
        end
    end

    assign rd_byte = mem[rd_idx];

    // Flattened view for the checker.
    for (genvar i = 0; i < N_BYTES; i++) begin : g_flat
        assign flat[8*i +: 8] = mem[i];
    end

endmodule

// File: rtl/otp_lock_bank.sv
// Sector lock bits plus the page check. A bit only ever goes 0 -> 1.
// Assumes: sectors are equal power-of-two slices taken from the top
// page-address bits.
module otp_lock_bank #(
    parameter int N_SECT = 4,
    parameter int SEC_W  = $clog2(N_SECT),
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [SEC_W-1:0]  set_idx,
    input  logic [7:0]        set_val,
    input  logic              acc_valid,
    input  logic [PAGE_W-1:0] acc_page,
    output logic              acc_reject,
    output logic [N_SECT-1:0] lock_bits
);

    localparam int SHIFT = PAGE_W - SEC_W;

    logic [N_SECT-1:0] hit;

    // Lock a sector on an FFh payload byte; every other value is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_bits <= '0;
        else if (set_en && set_val == 8'hFF) lock_bits[set_idx] <= 1'b1;
    end

    // Per-sector match of the requested page against locked sectors.
    for (genvar s = 0; s < N_SECT; s++) begin : g_hit
        assign hit[s] = lock_bits[s] && ((acc_page >> SHIFT) == PAGE_W'(s));
    end

    // Registered reject answer, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_reject <= 1'b0;
        else        acc_reject <= acc_valid && (|hit);
    end

endmodule

// File: rtl/otp_read_port.sv
// Sequential read-out for both read sessions. Pointer restarts at 0 on
// every session, saturates one past the area, and pads beyond the end.
// Assumes: restart and step are never asserted together.
module otp_read_port #(
    parameter int                        SEC_BYTES  = 128,
    parameter int                        N_SECT     = 4,
    parameter int                        PTR_W      = $clog2(SEC_BYTES) + 1,
    parameter int                        UIDX_W     = $clog2(SEC_BYTES / 2),
    parameter int                        SEC_W      = $clog2(N_SECT),
    parameter logic [7:0]                PAD_BYTE   = 8'h5A,
    parameter logic [4*SEC_BYTES-1:0]    FACTORY_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              is_lock,
    input  logic [7:0]        user_byte,
    output logic [UIDX_W-1:0] user_idx,
    input  logic [N_SECT-1:0] lock_bits,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    localparam int USER_BYTES = SEC_BYTES / 2;

    logic [PTR_W-1:0] ptr;
    logic [7:0]       nxt;

    assign user_idx = ptr[UIDX_W-1:0];

    // Select the byte at the pointer for the active read type.
    always_comb begin
        if (is_lock) begin
            nxt = (ptr < PTR_W'(N_SECT)) ? {8{lock_bits[ptr[SEC_W-1:0]]}} : PAD_BYTE;
        end else if (ptr < PTR_W'(USER_BYTES)) begin
            nxt = user_byte;
        end else if (ptr < PTR_W'(SEC_BYTES)) begin
            nxt = FACTORY_ID[{ptr[UIDX_W-1:0], 3'b000} +: 8];
        end else begin
            nxt = PAD_BYTE;
        end
    end

    // Advance the pointer and register the output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (restart) begin
            ptr      <= '0;
            rd_valid <= 1'b0;
        end else if (step) begin
            rd_data  <= nxt;
            rd_valid <= 1'b1;
            if (ptr != PTR_W'(SEC_BYTES)) ptr <= ptr + 1'b1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/otp_secure_regs.sv
// Top: session tracking and routing between the SPI front end, the
// write-once user store, the sector lock bank and the read port.
// Assumes: the front end has already removed opcode, address and dummy
// bytes and presents only payload bytes and read requests.
module otp_secure_regs #(
    parameter int                              SEC_BYTES  = 128,
    parameter int                              N_SECT     = 4,
    parameter int                              PAGE_W     = 9,
    parameter logic [7:0]                      PAD_BYTE   = 8'h5A,
    parameter logic [8*(SEC_BYTES/2)-1:0]      FACTORY_ID = otp_pkg::make_serial()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic [1:0]        sess_op,
    input  logic              sess_end,
    input  logic              din_valid,
    input  logic [7:0]        din,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic              acc_valid,
    input  logic [PAGE_W-1:0] acc_page,
    output logic              acc_reject,
    output logic [N_SECT-1:0] lock_mask
);

    import otp_pkg::*;

    localparam int USER_BYTES = SEC_BYTES / 2;
    localparam int PTR_W      = $clog2(SEC_BYTES) + 1;
    localparam int UIDX_W     = $clog2(USER_BYTES);
    localparam int SEC_W      = $clog2(N_SECT);

    otp_op_e                 cur_op;
    logic                    active;
    logic [PTR_W-1:0]        byte_cnt;
    logic                    user_wr, user_commit, lock_wr, rd_step, rd_lock;
    logic [7:0]              user_byte;
    logic [UIDX_W-1:0]       user_idx;
    logic                    sealed;
    logic [8*USER_BYTES-1:0] user_flat;

    // Session open/close and operation latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cur_op <= OP_SEC_RD;
        end else begin
            if (sess_end) active <= 1'b0;
            if (sess_start) begin
                active <= 1'b1;
                cur_op <= otp_op_e'(sess_op);
            end
        end
    end

    // Payload byte counter, saturating one past the area.
    always_ff @(posedge clk) begin
        if (!rst_n || sess_start) byte_cnt <= '0;
        else if (active && din_valid && byte_cnt != PTR_W'(SEC_BYTES))
            byte_cnt <= byte_cnt + 1'b1;
    end

    assign user_wr     = active && din_valid && cur_op == OP_SEC_WR
                         && byte_cnt < PTR_W'(USER_BYTES);
    assign user_commit = active && sess_end && cur_op == OP_SEC_WR;
    assign lock_wr     = active && din_valid && cur_op == OP_LCK_WR
                         && byte_cnt < PTR_W'(N_SECT);
    assign rd_lock     = cur_op == OP_LCK_RD;
    assign rd_step     = active && rd_req && !sess_start
                         && (cur_op == OP_SEC_RD || rd_lock);

    otp_user_array #(.N_BYTES(USER_BYTES), .IDX_W(UIDX_W)) u_user (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (user_wr),
        .wr_idx  (byte_cnt[UIDX_W-1:0]),
        .wr_data (din),
        .commit  (user_commit),
        .rd_idx  (user_idx),
        .rd_byte (user_byte),
        .sealed  (sealed),
        .flat    (user_flat)
    );

    otp_lock_bank #(.N_SECT(N_SECT), .SEC_W(SEC_W), .PAGE_W(PAGE_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (lock_wr),
        .set_idx    (byte_cnt[SEC_W-1:0]),
        .set_val    (din),
        .acc_valid  (acc_valid),
        .acc_page   (acc_page),
        .acc_reject (acc_reject),
        .lock_bits  (lock_mask)
    );

    otp_read_port #(
        .SEC_BYTES  (SEC_BYTES),
        .N_SECT     (N_SECT),
        .PTR_W      (PTR_W),
        .UIDX_W     (UIDX_W),
        .SEC_W      (SEC_W),
        .PAD_BYTE   (PAD_BYTE),
        .FACTORY_ID (FACTORY_ID)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (sess_start),
        .step      (rd_step),
        .is_lock   (rd_lock),
        .user_byte (user_byte),
        .user_idx  (user_idx),
        .lock_bits (lock_mask),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/otp_secure_regs_chk.sv
// Property checker for otp_secure_regs, attached by bind below.
// Assumes: observes ports plus the seal flag and flattened user store.
module otp_secure_regs_chk #(
    parameter int N_SECT     = 4,
    parameter int USER_BYTES = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_req,
    input logic                    rd_valid,
    input logic                    acc_valid,
    input logic                    acc_reject,
    input logic [N_SECT-1:0]       lock_mask,
    input logic                    sealed,
    input logic [8*USER_BYTES-1:0] user_flat
);

    logic past_ok;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_LOCK_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((~lock_mask & $past(lock_mask)) == '0));             // R9
    AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(sealed) |-> sealed);                             // R6
    AST_SEALED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(sealed) |-> $stable(user_flat));                 // R6
    AST_REJECT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && acc_reject |-> $past(acc_valid) && $past(lock_mask) != '0); // R10
    AST_RDVALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rd_valid |-> $past(rd_req));                           // R2

endmodule

bind otp_secure_regs otp_secure_regs_chk #(
    .N_SECT     (N_SECT),
    .USER_BYTES (SEC_BYTES / 2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .acc_valid  (acc_valid),
    .acc_reject (acc_reject),
    .lock_mask  (lock_mask),
    .sealed     (sealed),
    .user_flat  (user_flat)
);

// File: tb/sim_otp_secure_regs.sv
`timescale 1ns/1ps
module sim_otp_secure_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sess_start = 0, sess_end = 0, din_valid = 0, rd_req = 0, acc_valid = 0;
    logic [1:0] sess_op = 0;
    logic [7:0] din = 0;
    logic [8:0] acc_page = 0;
    logic       rd_valid, acc_reject;
    logic [7:0] rd_data;
    logic [3:0] lock_mask;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] m_user [64];
    bit         m_sealed;
    bit         m_lock [4];

    always #2.5 clk = ~clk;

    otp_secure_regs u0 (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_op(sess_op),
        .sess_end(sess_end), .din_valid(din_valid), .din(din), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_valid(acc_valid),
        .acc_page(acc_page), .acc_reject(acc_reject), .lock_mask(lock_mask)
    );

    function automatic logic [7:0] fact(int k);
        return 8'(k * 29) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_sec(int k);
        if (k < 64)  return m_user[k];
        if (k < 128) return fact(k - 64);
        return 8'h5A;
    endfunction

    function automatic logic [7:0] exp_lck(int k);
        if (k < 4) return m_lock[k] ? 8'hFF : 8'h00;
        return 8'h5A;
    endfunction

    function automatic logic [3:0] exp_mask();
        return {m_lock[3], m_lock[2], m_lock[1], m_lock[0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 64; i++) m_user[i] = 8'hFF;
        for (int i = 0; i < 4; i++) m_lock[i] = 0;
        m_sealed = 0;
        @(negedge clk);
    endtask

    task automatic open_s(logic [1:0] op);
        sess_start = 1; sess_op = op;
        @(negedge clk);
        sess_start = 0;
    endtask

    task automatic close_s();
        sess_end = 1;
        @(negedge clk);
        sess_end = 0;
    endtask

    task automatic push(logic [7:0] b);
        din_valid = 1; din = b;
        @(negedge clk);
        din_valid = 0;
    endtask

    // Program the security area with n bytes, updating the model.
    task automatic prog_sec(int n);
        open_s(2'b01);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'($urandom);
            if (!m_sealed && i < 64) m_user[i] = b;
            push(b);
        end
        close_s();
        m_sealed = 1;
    endtask

    task automatic prog_lock(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                             logic [7:0] b3, logic [7:0] b4);
        logic [7:0] v [5];
        v = '{b0, b1, b2, b3, b4};
        open_s(2'b11);
        for (int i = 0; i < 5; i++) begin
            if (i < 4 && v[i] == 8'hFF) m_lock[i] = 1;
            push(v[i]);
        end
        close_s();
    endtask

    task automatic read_sec(int n, string tag);
        open_s(2'b00);
        for (int k = 0; k < n; k++) begin
            rd_req = 1;
            @(negedge clk);
            rd_req = 0;
            chk({tag, " rd_valid"}, rd_valid, 1);
            chk({tag, " sec byte"}, rd_data, exp_sec(k));
        end
        close_s();
    endtask

    task automatic read_lock(string tag);
        open_s(2'b10);
        for (int k = 0; k < 6; k++) begin
            rd_req = 1;
            @(negedge clk);
            rd_req = 0;
            chk({tag, " lock byte"}, rd_data, exp_lck(k));
        end
        close_s();
        chk({tag, " lock_mask"}, lock_mask, exp_mask());
    endtask

    task automatic page_chk(logic [8:0] p);
        acc_valid = 1; acc_page = p;
        @(negedge clk);
        acc_valid = 0;
        chk("R10 acc_reject", acc_reject, m_lock[p[8:7]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd7));
        do_reset();
        // R1: reset state
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 acc_reject", acc_reject, 0);
        chk("R1 lock_mask", lock_mask, 0);
        // R2 R3 R4: full pass through unprogrammed area and past its end
        read_sec(131, "R2/R3/R4");
        // R11: reads and bytes with no session open
        rd_req = 1; @(negedge clk); rd_req = 0;
        chk("R11 idle rd_valid", rd_valid, 0);
        push(8'h00); push(8'hFF);
        read_lock("R11 idle lock");
        // R5: first program, 40 bytes, rest stays FFh
        prog_sec(40);
        push(8'h12);                          // R11 after close
        read_sec(130, "R5");
        // R6: later programs ignored, including long streams
        prog_sec(70);
        read_sec(130, "R6");
        // R7 R8: lock program with mixed values and an extra byte
        read_lock("R7 empty");
        prog_lock(8'h00, 8'hFF, 8'h5A, 8'hFF, 8'hFF);
        read_lock("R8 mixed");
        // R9: 00h never unlocks
        prog_lock(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        read_lock("R9 sticky");
        prog_lock(8'hFF, 8'h7F, 8'h00, 8'h01, 8'h00);
        read_lock("R8 sector0");
        // R10: page checks, directed bounds then random
        page_chk(9'h000); page_chk(9'h07F); page_chk(9'h080); page_chk(9'h17F);
        page_chk(9'h100); page_chk(9'h1FF);
        for (int i = 0; i < 40; i++) page_chk(9'($urandom));
        @(negedge clk);
        chk("R10 no request", acc_reject, 0);
        // Random mixed sessions from a fresh reset
        do_reset();
        chk("R1 lock_mask again", lock_mask, 0);
        for (int it = 0; it < 20; it++) begin
            case ($urandom % 3)
                0: prog_sec(int'($urandom % 72));
                1: prog_lock(($urandom % 2) ? 8'hFF : 8'($urandom),
                             ($urandom % 2) ? 8'hFF : 8'($urandom),
                             ($urandom % 3) ? 8'h00 : 8'hFF,
                             ($urandom % 3) ? 8'($urandom) : 8'hFF, 8'hFF);
                default: page_chk(9'($urandom));
            endcase
            if (it % 4 == 3) begin
                read_sec(130, "R5/R6 random");
                read_lock("R8/R9 random");
            end
        end
        report();
    end

endmodule